// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the timer of a per-processor local interrupt controller. Software programs three things through single-cycle write strobes: a divide shift that sets how many input clocks make one timer tick, a timer vector entry (mask bit, periodic/one-shot mode bit and an 8-bit vector), and an initial count. Writing the initial count starts a new countdown from the current clock edge. When the programmed number of ticks has elapsed, the timer raises a one-cycle interrupt request that carries the vector.

In periodic mode the countdown reloads on every expiry, so requests arrive at a fixed spacing for as long as the timer runs. In one-shot mode the timer fires once and then goes idle until the count is written again. A current-count output shows how far the present period has progressed. An armed flag shows whether an unmasked expiry is scheduled. Masking suppresses requests and clears the armed flag, but the countdown keeps running underneath.

Top module: `ltmr_timer`

## Requirements
- R1: After reset the timer is idle (armed low, current count zero, no request), the divide shift and mode bit are zero, and the mask bit is set. A count written without first writing the vector entry therefore raises no request.
- R2: With divide shift s, one tick occurs every 2^s input clocks. Ticks are counted from the edge that samples the count write, so tick j falls on edge j*2^s after that write.
- R3: In periodic mode (mode bit 1) with initial count N > 0, a request occurs on every edge k after the write where k = m*(N+1)*2^s for m >= 1.
- R4: In periodic mode with N = 0 the timer never expires. Armed and current count read as zero.
- R5: In one-shot mode (mode bit 0) exactly one request occurs, on edge (N+1)*2^s after the write. From that edge on, armed and current count read zero until the next count write.
- R6: While the mask bit is set, armed reads low and no request is raised. An expiry inside the masked interval is dropped. Clearing the mask does not restart the count, and later expiries keep their original schedule.
- R7: A request is high for one cycle only and carries the 8-bit vector of the timer entry.
- R8: Every count write restarts the prescaler and the period from that edge, even if the written value equals the current one.
- R9: While the timer runs, the current count equals N minus the number of ticks elapsed in the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCount | input | 1 | Strobe: load countData as the initial count |
| countData | input | CNT_W | Initial count value |
| wrDiv | input | 1 | Strobe: load divShift |
| divShift | input | SHIFT_W | Prescale shift (tick every 2^divShift clocks) |
| wrVec | input | 1 | Strobe: load the timer vector entry |
| vecMask | input | 1 | Entry mask bit (1 = masked) |
| vecPeriodic | input | 1 | Entry mode bit (1 = periodic, 0 = one-shot) |
| vecNum | input | VEC_W | Entry interrupt vector |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | VEC_W | Vector carried by the request |
| curCount | output | CNT_W | Current count readback |
| armed | output | 1 | An unmasked expiry is scheduled |

## Verification
Four properties hold on every cycle. The phase never runs past the initial count. A one-shot expiry always stops the countdown. A request never lasts two cycles and never appears while the mask has been held. A count write always shows the written value as the new current count. The exact expiry edges for each combination of shift, count and mode, and the behaviour across mask toggles and repeated writes, can only be shown by the bench's scenarios. The bench compares every cycle of those scenarios against a schedule it computes arithmetically.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic load;      // initial count written this cycle
    logic tick;      // prescaled tick (suppressed on load)
    logic periodic;  // current mode bit of the timer entry
  } ltmr_strobe_t;
endpackage

// File: rtl/ltmr_ctrl.sv
module ltmr_ctrl
  import ltmr_pkg::*;
#(
  parameter int SHIFT_W = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrCount,
  input  logic               wrDiv,
  input  logic [SHIFT_W-1:0] divShift,
  input  logic               wrVec,
  input  logic               vecMask,
  input  logic               vecPeriodic,
  input  logic [VEC_W-1:0]   vecNum,
  input  logic               hit,
  input  logic               busy,
  output ltmr_strobe_t       strb,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic               armed
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shiftQ;
  logic               maskQ;
  logic               periodicQ;
  logic [VEC_W-1:0]   vecQ;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W:0]     span;
  logic [PRE_W-1:0]   divMask;
  logic               tickRaw;

  always_comb begin
    span    = {{PRE_W{1'b0}}, 1'b1} << shiftQ;
    divMask = span[PRE_W-1:0] - PRE_W'(1);
    tickRaw = (preCnt >= divMask);
  end

  assign strb.load     = wrCount;
  assign strb.tick     = tickRaw & ~wrCount;
  assign strb.periodic = periodicQ;
  assign armed         = busy & ~maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ    <= '0;
      maskQ     <= 1'b1;
      periodicQ <= 1'b0;
      vecQ      <= '0;
      preCnt    <= '0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      if (wrDiv) shiftQ <= divShift;
      if (wrVec) begin
        maskQ     <= vecMask;
        periodicQ <= vecPeriodic;
        vecQ      <= vecNum;
      end
      if (wrCount || tickRaw) preCnt <= '0;
      else                    preCnt <= preCnt + PRE_W'(1);
      irqValid <= hit & ~maskQ;
      if (hit) irqVector <= vecQ;
    end
  end

  // R7: a request never lasts more than one cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);

  // R6: no request while the mask has been held across the deciding edge
  p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ && $past(maskQ)) |-> !irqValid);
endmodule

// File: rtl/ltmr_datapath.sv
module ltmr_datapath
  import ltmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ltmr_strobe_t     strb,
  input  logic [CNT_W-1:0] loadData,
  output logic             hit,
  output logic             busy,
  output logic [CNT_W-1:0] curCount
);
  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] phase;
  logic             runQ;

  always_comb begin
    busy     = runQ & ~(strb.periodic & (initCount == '0));
    hit      = busy & strb.tick & (phase == initCount);
    curCount = busy ? (initCount - phase) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCount <= '0;
      phase     <= '0;
      runQ      <= 1'b0;
    end else if (strb.load) begin
      initCount <= loadData;
      phase     <= '0;
      runQ      <= 1'b1;
    end else if (hit) begin
      phase <= '0;
      if (!strb.periodic) runQ <= 1'b0;
    end else if (strb.tick && busy) begin
      phase <= phase + CNT_W'(1);
    end
  end

  // R9: the phase never passes the initial count while running
  p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phase <= initCount));

  // R5: a one-shot expiry stops the countdown
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !strb.periodic) |=> !busy);

  // R8: a count write shows the new value as the current count
  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> (!busy || curCount == $past(loadData)));
endmodule

// File: rtl/ltmr_timer.sv
module ltmr_timer
  import ltmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrCount,
  input  logic [CNT_W-1:0]   countData,
  input  logic               wrDiv,
  input  logic [SHIFT_W-1:0] divShift,
  input  logic               wrVec,
  input  logic               vecMask,
  input  logic               vecPeriodic,
  input  logic [VEC_W-1:0]   vecNum,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic [CNT_W-1:0]   curCount,
  output logic               armed
);
  ltmr_strobe_t strb;
  logic         hit;
  logic         busy;

  ltmr_ctrl #(.SHIFT_W(SHIFT_W), .VEC_W(VEC_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrCount(wrCount), .wrDiv(wrDiv), .divShift(divShift),
    .wrVec(wrVec), .vecMask(vecMask), .vecPeriodic(vecPeriodic), .vecNum(vecNum),
    .hit(hit), .busy(busy), .strb(strb),
    .irqValid(irqValid), .irqVector(irqVector), .armed(armed)
  );

  ltmr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(countData),
    .hit(hit), .busy(busy), .curCount(curCount)
  );
endmodule

// File: tb/ltmr_timer_tb.sv
module ltmr_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SHIFT_W = 3;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCount = 1'b0;
  logic [CNT_W-1:0] countData = '0;
  logic wrDiv = 1'b0;
  logic [SHIFT_W-1:0] divShift = '0;
  logic wrVec = 1'b0;
  logic vecMask = 1'b0;
  logic vecPeriodic = 1'b0;
  logic [VEC_W-1:0] vecNum = '0;
  logic irqValid;
  logic [VEC_W-1:0] irqVector;
  logic [CNT_W-1:0] curCount;
  logic armed;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltmr_timer #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .VEC_W(VEC_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .countData(countData),
    .wrDiv(wrDiv), .divShift(divShift), .wrVec(wrVec), .vecMask(vecMask),
    .vecPeriodic(vecPeriodic), .vecNum(vecNum), .irqValid(irqValid),
    .irqVector(irqVector), .curCount(curCount), .armed(armed)
  );

  task automatic report(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected outputs k edges after the count write
  task automatic checkCycle(input string tag, input int k, input int s, input int n,
                            input bit per, input bit msk, input int vec);
    int ticks = k >> s;
    bit onEdge = (k % (1 << s)) == 0;
    bit eBusy;
    bit eIrq;
    int eCur;
    if (per) begin
      if (n == 0) begin eBusy = 0; eCur = 0; eIrq = 0; end
      else begin
        eBusy = 1;
        eCur = n - (ticks % (n + 1));
        eIrq = onEdge && ticks > 0 && (ticks % (n + 1)) == 0;
      end
    end else begin
      if (ticks < n + 1) begin eBusy = 1; eCur = n - ticks; end
      else begin eBusy = 0; eCur = 0; end
      eIrq = (k == ((n + 1) << s));
    end
    report(tag, "curCount", int'(curCount), eCur);
    report(tag, "armed", int'(armed), int'(eBusy && !msk));
    report(tag, "irqValid", int'(irqValid), int'(eIrq && !msk));
    if (eIrq && !msk) report(tag, "irqVector", int'(irqVector), vec);
  endtask

  task automatic runCheck(input string tag, input int ks, input int ke, input int s,
                          input int n, input bit per, input bit msk, input int vec);
    for (int k = ks; k <= ke; k++) begin
      @(negedge clk);
      checkCycle(tag, k, s, n, per, msk, vec);
    end
  endtask

  task automatic setLvt(input bit msk, input bit per, input int vec);
    vecMask = msk; vecPeriodic = per; vecNum = VEC_W'(vec); wrVec = 1'b1;
    @(negedge clk);
    wrVec = 1'b0;
  endtask

  task automatic setShift(input int s);
    divShift = SHIFT_W'(s); wrDiv = 1'b1;
    @(negedge clk);
    wrDiv = 1'b0;
  endtask

  task automatic writeCount(input int n);
    countData = CNT_W'(n); wrCount = 1'b1;
    @(negedge clk);
    wrCount = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    report("R1", "armed", int'(armed), 0);
    report("R1", "curCount", int'(curCount), 0);
    report("R1", "irqValid", int'(irqValid), 0);
    // R1: default entry is masked one-shot, shift 0
    writeCount(2);
    checkCycle("R1", 0, 0, 2, 0, 1, 0);
    runCheck("R1", 1, 8, 0, 2, 0, 1, 0);

    // R2 R3 R4 R5 R7 R9: sweep of shift, count and mode
    for (int s = 0; s <= 2; s++)
      for (int n = 0; n <= 3; n++)
        for (int per = 0; per <= 1; per++) begin
          int vec = 8'h40 + s * 16 + n * 2 + per;
          setLvt(1, per[0], vec);
          setShift(s);
          setLvt(0, per[0], vec);
          writeCount(n);
          checkCycle(per ? "R3 R4 R2 R9 R7" : "R5 R2 R9 R7", 0, s, n, per[0], 0, vec);
          runCheck(per ? "R3 R4 R2 R9 R7" : "R5 R2 R9 R7",
                   1, 3 * (n + 1) * (1 << s) + 3, s, n, per[0], 0, vec);
        end

    // R6: mask mid-run, expiry at edge 12 dropped, schedule kept after unmask
    setShift(1);
    setLvt(0, 1, 8'hA5);
    writeCount(2);
    runCheck("R6", 1, 7, 1, 2, 1, 0, 8'hA5);
    setLvt(1, 1, 8'hA5);                 // consumes edge 8
    runCheck("R6", 9, 15, 1, 2, 1, 1, 8'hA5);
    setLvt(0, 1, 8'hA5);                 // consumes edge 16
    runCheck("R6", 17, 26, 1, 2, 1, 0, 8'hA5);

    // R8: rewrite of the same value restarts the period
    setShift(0);
    setLvt(0, 1, 8'h3C);
    writeCount(4);
    runCheck("R8", 1, 3, 0, 4, 1, 0, 8'h3C);
    writeCount(4);
    checkCycle("R8", 0, 0, 4, 1, 0, 8'h3C);
    runCheck("R8", 1, 12, 0, 4, 1, 0, 8'h3C);

    // R8: rewrite restarts the prescaler partway through a tick
    setShift(2);
    setLvt(0, 0, 8'h77);
    writeCount(1);
    runCheck("R8", 1, 2, 2, 1, 0, 0, 8'h77);
    writeCount(1);
    checkCycle("R8", 0, 2, 1, 0, 0, 8'h77);
    runCheck("R8", 1, 12, 2, 1, 0, 0, 8'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule